// File: doc/BRIEF.md
# Flash Erase-Suspend Sequencer

This block sequences long erase and program operations on a flash array split into blocks, and arbitrates them against interrupt requests and CPU accesses to the array. A one-cycle command pulse starts either an erase of one block or a program operation. The operation is modelled as a down-counter that raises a one-cycle done flag when it finishes. An erase can be frozen partway through. A suspend request, raised either by software or by an interrupt when auto-suspend is enabled, takes effect only after a fixed delay of `SUSP_DLY` cycles. Clearing the request resumes the erase from the count at which it stopped. A program operation cannot be suspended.

Interrupts pass through the block. When `hold_mode` is 0, the interrupt handler runs from memory outside the flash and every request is forwarded at once. When `hold_mode` is 1, the handler needs the flash. A request is then held while the array is busy and is released only when the array goes idle or the erase has actually entered the suspended state. An access check reports, one cycle after each request, whether a CPU read or write of a given block may proceed.

Top module: `fes_seq`

## Requirements
- R1: After reset, all outputs are 0. An erase command accepted while idle makes `busy` 1 from the next cycle for exactly `ERASE_CYC` cycles, and a program command does the same for `PROG_CYC` cycles. `op_done` is 1 for one cycle, in the first cycle after `busy` falls.
- R2: A command is accepted only while idle and not suspended. If erase and program are both requested in the same idle cycle, the erase is taken. A command issued while an operation is busy or suspended is ignored.
- R3: A suspend request written during an erase makes `susp_pend` 1 from the next cycle. `susp_pend` stays 1 for `SUSP_DLY` cycles, after which `suspended` becomes 1 and `busy` becomes 0. The erase keeps counting during the delay. If the erase finishes first, it completes normally and the request clears.
- R4: A control write sets the auto-suspend bit, and `stat_auto` reads it back. When this bit is 1, `irq_in` during a running erase sets the suspend request, visible on `stat_susp` in the next cycle. When this bit is 0, an interrupt leaves the request unchanged.
- R5: While suspended, the erase count is frozen. A control write with the suspend bit at 0 resumes the erase in the next cycle. Over one erase, the busy cycles add up to `ERASE_CYC`, however many suspensions occur.
- R6: Writing 0 to the suspend bit while the delay is still counting cancels the suspend, and the erase never enters the suspended state.
- R7: A write of 1 to the suspend bit while idle or while programming has no effect, and `stat_susp` stays 0. A program operation is never suspended.
- R8: With `hold_mode` at 0, every `irq_in` pulse produces an `irq_fire` pulse in the next cycle.
- R9: With `hold_mode` at 1, an interrupt that arrives while `busy` is 1 is held and fires in the first cycle after the array is idle or suspended. An interrupt that arrives while idle or suspended fires in the next cycle. No interrupt is lost.
- R10: One cycle after `acc_req`, exactly one of `acc_ok` or `acc_err` is 1. `acc_ok` is given when the array is idle, or when it is suspended and `acc_blk` differs from the block under erase. Any other case gives `acc_err` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hold_mode | input | 1 | 1: interrupt handling needs the flash, so requests are held |
| cmd_erase | input | 1 | Erase command pulse |
| cmd_prog | input | 1 | Program command pulse |
| cmd_blk | input | BW | Block to erase |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_susp | input | 1 | Suspend-request bit value to write |
| ctl_auto | input | 1 | Auto-suspend-enable bit value to write |
| irq_in | input | 1 | Incoming interrupt request pulse |
| acc_req | input | 1 | CPU access request to the array |
| acc_blk | input | BW | Block targeted by the access |
| busy | output | 1 | Erase or program running and not suspended |
| suspended | output | 1 | Erase frozen |
| susp_pend | output | 1 | Suspend delay counting |
| stat_susp | output | 1 | Suspend-request bit readback |
| stat_auto | output | 1 | Auto-suspend-enable bit readback |
| op_done | output | 1 | Operation finished (one-cycle pulse) |
| irq_fire | output | 1 | Interrupt released to the CPU |
| acc_ok | output | 1 | Access granted |
| acc_err | output | 1 | Access rejected |

## Verification
Every result is registered. Status and readback outputs change in the cycle after the edge that samples a command, a control write or an interrupt. The access verdict and the forwarded interrupt also appear one cycle after their request. `suspended` rises `SUSP_DLY` cycles after `susp_pend`. The bench drives inputs just after the falling edge, steps a cycle-level reference model with those same inputs, and compares every output at the next falling edge. Each expected value is therefore compared in exactly the cycle it is due. Directed phases also count whole busy and suspended intervals against `ERASE_CYC` and `PROG_CYC`.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_HALT  = 2'd3
  } op_e;
endpackage

// File: rtl/fes_susp_timer.sv
module fes_susp_timer #(
  parameter int SUSP_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  output logic expired
);
  localparam int W = (SUSP_DLY > 1) ? $clog2(SUSP_DLY) : 1;
  localparam logic [W-1:0] RELOAD = W'(SUSP_DLY - 1);

  logic [W-1:0] dly_q, dly_d;

  always_comb begin
    dly_d = dly_q;
    if (!pend)
      dly_d = RELOAD;
    else if (dly_q != '0)
      dly_d = dly_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= RELOAD;
    else        dly_q <= dly_d;
  end

  assign expired = pend && (dly_q == '0);

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> (dly_q == RELOAD)); // R3
endmodule

// File: rtl/fes_irq_gate.sv
module fes_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic hold_mode,
  input  logic may_release,
  output logic irq_fire,
  output logic irq_held
);
  logic pend_q, pend_d, fire_q, fire_d, want;

  always_comb begin
    want   = pend_q | irq_in;
    fire_d = want & (~hold_mode | may_release);
    pend_d = want & ~fire_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      fire_q <= fire_d;
    end
  end

  assign irq_fire = fire_q;
  assign irq_held = pend_q;

  AST_IRQ_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> (irq_fire || irq_held)); // R9
  AST_IRQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in && !hold_mode) |=> irq_fire); // R8
endmodule

// File: rtl/fes_acc_chk.sv
module fes_acc_chk #(
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_req,
  input  logic [BW-1:0] acc_blk,
  input  logic          idle,
  input  logic          halted,
  input  logic [BW-1:0] ers_blk,
  output logic          acc_ok,
  output logic          acc_err
);
  logic ok_q, ok_d, err_q, err_d, allow;

  always_comb begin
    allow = idle | (halted & (acc_blk != ers_blk));
    ok_d  = acc_req & allow;
    err_d = acc_req & ~allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      err_q <= err_d;
    end
  end

  assign acc_ok  = ok_q;
  assign acc_err = err_q;

  AST_ACC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_ok, acc_err})); // R10
  AST_ACC_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> (acc_ok || acc_err)); // R10
endmodule

// File: rtl/fes_seq.sv
module fes_seq #(
  parameter int NBLK      = 8,
  parameter int ERASE_CYC = 1000,
  parameter int PROG_CYC  = 64,
  parameter int SUSP_DLY  = 16,
  localparam int BW       = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_mode,
  input  logic          cmd_erase,
  input  logic          cmd_prog,
  input  logic [BW-1:0] cmd_blk,
  input  logic          ctl_wr,
  input  logic          ctl_susp,
  input  logic          ctl_auto,
  input  logic          irq_in,
  input  logic          acc_req,
  input  logic [BW-1:0] acc_blk,
  output logic          busy,
  output logic          suspended,
  output logic          susp_pend,
  output logic          stat_susp,
  output logic          stat_auto,
  output logic          op_done,
  output logic          irq_fire,
  output logic          acc_ok,
  output logic          acc_err
);
  import fes_pkg::*;

  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  op_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d, auto_q, auto_d, done_q, done_d;
  logic [BW-1:0] blk_q, blk_d;
  logic          erasing, halted, pend, dly_exp, auto_hit, irq_held;

  assign erasing  = (st_q == OP_ERASE);
  assign halted   = (st_q == OP_HALT);
  assign pend     = erasing & req_q;
  assign auto_hit = irq_in & auto_q & erasing;

  fes_susp_timer #(.SUSP_DLY(SUSP_DLY)) u_timer (
    .clk(clk), .rst_n(rst_s), .pend(pend), .expired(dly_exp)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    req_d  = req_q;
    auto_d = auto_q;
    blk_d  = blk_q;
    done_d = 1'b0;
    if (ctl_wr) auto_d = ctl_auto;
    if (erasing || halted) begin
      if (ctl_wr)        req_d = ctl_susp;
      else if (auto_hit) req_d = 1'b1;
    end
    unique case (st_q)
      OP_IDLE: begin
        if (cmd_erase) begin
          st_d  = OP_ERASE;
          cnt_d = CW'(ERASE_CYC - 1);
          blk_d = cmd_blk;
        end else if (cmd_prog) begin
          st_d  = OP_PROG;
          cnt_d = CW'(PROG_CYC - 1);
        end
      end
      OP_ERASE: begin
        if (cnt_q == '0) begin
          st_d   = OP_IDLE;
          done_d = 1'b1;
          req_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - CW'(1);
          if (dly_exp && req_d) st_d = OP_HALT;
        end
      end
      OP_PROG: begin
        if (cnt_q == '0) begin
          st_d   = OP_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      OP_HALT: begin
        if (!req_d) st_d = OP_ERASE;
      end
      default: st_d = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= OP_IDLE;
      cnt_q  <= '0;
      req_q  <= 1'b0;
      auto_q <= 1'b0;
      blk_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
      auto_q <= auto_d;
      blk_q  <= blk_d;
      done_q <= done_d;
    end
  end

  fes_irq_gate u_irq (
    .clk(clk), .rst_n(rst_s), .irq_in(irq_in), .hold_mode(hold_mode),
    .may_release((st_q == OP_IDLE) | halted),
    .irq_fire(irq_fire), .irq_held(irq_held)
  );

  fes_acc_chk #(.BW(BW)) u_acc (
    .clk(clk), .rst_n(rst_s), .acc_req(acc_req), .acc_blk(acc_blk),
    .idle(st_q == OP_IDLE), .halted(halted), .ers_blk(blk_q),
    .acc_ok(acc_ok), .acc_err(acc_err)
  );

  assign busy      = erasing | (st_q == OP_PROG);
  assign suspended = halted;
  assign susp_pend = pend;
  assign stat_susp = req_q;
  assign stat_auto = auto_q;
  assign op_done   = done_q;

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    op_done |-> $past(busy)); // R1
  AST_HALT_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(suspended) |-> $past(susp_pend)); // R3
  AST_AUTO_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_in && auto_q && erasing && !ctl_wr && cnt_q != '0) |=> stat_susp); // R4
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_s)
    (suspended && $past(suspended)) |-> $stable(cnt_q)); // R5
  AST_PROG_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == OP_PROG) |-> (!req_q && !suspended)); // R7
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_fire && $past(hold_mode)) |-> $past(!busy)); // R9
  AST_ACC_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_s)
    (acc_req && !cmd_erase && !cmd_prog && !ctl_wr && !irq_in && st_q == OP_HALT)
      |=> (st_q == OP_HALT)); // R10
endmodule

// File: tb/fes_seq_test.sv
module fes_seq_test;
  localparam int NBLK = 4, ERASE_CYC = 40, PROG_CYC = 12, SUSP_DLY = 5;
  localparam int BW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold_mode = 0, cmd_erase = 0, cmd_prog = 0, ctl_wr = 0, ctl_susp = 0;
  logic ctl_auto = 0, irq_in = 0, acc_req = 0;
  logic [BW-1:0] cmd_blk = '0, acc_blk = '0;
  logic busy, suspended, susp_pend, stat_susp, stat_auto, op_done, irq_fire, acc_ok, acc_err;

  always #4 clk = ~clk;  // 125 MHz

  fes_seq #(.NBLK(NBLK), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .SUSP_DLY(SUSP_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .cmd_erase(cmd_erase), .cmd_prog(cmd_prog),
    .cmd_blk(cmd_blk), .ctl_wr(ctl_wr), .ctl_susp(ctl_susp), .ctl_auto(ctl_auto), .irq_in(irq_in),
    .acc_req(acc_req), .acc_blk(acc_blk), .busy(busy), .suspended(suspended), .susp_pend(susp_pend),
    .stat_susp(stat_susp), .stat_auto(stat_auto), .op_done(op_done), .irq_fire(irq_fire),
    .acc_ok(acc_ok), .acc_err(acc_err));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 erase, 2 program, 3 suspended
  int m_st = 0, m_cnt = 0, m_dly = SUSP_DLY - 1, m_blk = 0;
  bit m_req = 0, m_auto = 0, m_done = 0, m_ip = 0, m_fire = 0, m_ok = 0, m_err = 0;

  task automatic chk(string req, string name, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic m_step();
    bit pend = (m_st == 1) && m_req;
    bit dexp = pend && (m_dly == 0);
    bit ahit = irq_in && m_auto && (m_st == 1);
    bit p, rel;
    int n_st = m_st, n_cnt = m_cnt;
    bit n_req = m_req, n_done = 0;
    m_dly = !pend ? SUSP_DLY - 1 : (m_dly != 0 ? m_dly - 1 : 0);
    if (m_st == 1 || m_st == 3) begin
      if (ctl_wr) n_req = ctl_susp; else if (ahit) n_req = 1;
    end
    case (m_st)
      0: if (cmd_erase) begin n_st = 1; n_cnt = ERASE_CYC - 1; m_blk = cmd_blk; end
         else if (cmd_prog) begin n_st = 2; n_cnt = PROG_CYC - 1; end
      1: if (m_cnt == 0) begin n_st = 0; n_done = 1; n_req = 0; end
         else begin n_cnt = m_cnt - 1; if (dexp && n_req) n_st = 3; end
      2: if (m_cnt == 0) begin n_st = 0; n_done = 1; end else n_cnt = m_cnt - 1;
      default: if (!n_req) n_st = 1;
    endcase
    p = m_ip || irq_in;
    rel = !hold_mode || m_st == 0 || m_st == 3;
    m_fire = p && rel;
    m_ip = p && !rel;
    m_ok  = acc_req && (m_st == 0 || (m_st == 3 && acc_blk != m_blk[BW-1:0]));
    m_err = acc_req && !(m_st == 0 || (m_st == 3 && acc_blk != m_blk[BW-1:0]));
    if (ctl_wr) m_auto = ctl_auto;
    m_st = n_st; m_cnt = n_cnt; m_req = n_req; m_done = n_done;
  endtask

  task automatic compare_all();
    chk("R1", "busy", busy, (m_st == 1 || m_st == 2));
    chk("R1", "op_done", op_done, m_done);
    chk("R5", "suspended", suspended, m_st == 3);
    chk("R3", "susp_pend", susp_pend, (m_st == 1) && m_req);
    chk("R7", "stat_susp", stat_susp, m_req);
    chk("R4", "stat_auto", stat_auto, m_auto);
    chk(hold_mode ? "R9" : "R8", "irq_fire", irq_fire, m_fire);
    chk("R10", "acc_ok", acc_ok, m_ok);
    chk("R10", "acc_err", acc_err, m_err);
  endtask

  // one cycle: inputs already set at a falling edge
  task automatic tick();
    m_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    cmd_erase = 0; cmd_prog = 0; ctl_wr = 0; irq_in = 0; acc_req = 0;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_ctl(bit s, bit a);
    ctl_wr = 1; ctl_susp = s; ctl_auto = a; tick();
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int bcount, scount;
    bit seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset outputs", {suspended, susp_pend, stat_susp, stat_auto, op_done, irq_fire, acc_ok, acc_err}, 0);

    // R1, R2: erase and program together -> erase length; program during it ignored
    cmd_erase = 1; cmd_prog = 1; cmd_blk = 2; tick();
    bcount = 1;
    cmd_prog = 1; tick(); bcount++;
    while (busy) begin tick(); bcount++; end
    chk("R2", "erase wins, busy cycles", bcount - 1, ERASE_CYC);
    chk("R1", "done after erase", op_done, 1);
    idle_n(2);
    cmd_prog = 1; tick(); bcount = 0;
    while (busy) begin bcount++; tick(); end
    chk("R1", "program busy cycles", bcount, PROG_CYC);

    // R7: suspend write while idle and while programming has no effect
    wr_ctl(1, 0);
    chk("R7", "idle req readback", stat_susp, 0);
    cmd_prog = 1; tick(); wr_ctl(1, 0); idle_n(2);
    chk("R7", "prog req readback", stat_susp, 0);
    while (busy) tick();

    // R3, R5: suspend, access other/same block, resume, total busy = ERASE_CYC
    cmd_erase = 1; cmd_blk = 1; tick();
    bcount = 1; scount = 0;
    idle_n(8); bcount += 8;
    wr_ctl(1, 0); bcount++;
    chk("R3", "pending after write", susp_pend, 1);
    while (!suspended) begin tick(); bcount++; end
    acc_req = 1; acc_blk = 3; tick(); scount++;
    chk("R10", "other block ok", acc_ok, 1);
    acc_req = 1; acc_blk = 1; tick(); scount++;
    chk("R10", "erased block err", acc_err, 1);
    chk("R10", "no state change", suspended, 1);
    idle_n(6); scount += 6;
    wr_ctl(0, 0);
    chk("R5", "resumed", busy, 1);
    while (busy) begin tick(); bcount++; end
    chk("R5", "busy total with suspend", bcount - 1, ERASE_CYC);

    // R6: cancel during delay
    cmd_erase = 1; tick(); wr_ctl(1, 0); tick(); wr_ctl(0, 0);
    seen = 0;
    while (busy) begin tick(); if (suspended) seen = 1; end
    chk("R6", "cancel never suspends", seen, 0);

    // R4: auto-suspend off then on
    wr_ctl(0, 0);
    cmd_erase = 1; tick(); idle_n(2); irq_in = 1; tick();
    chk("R4", "no auto suspend", stat_susp, 0);
    while (busy) tick();
    wr_ctl(0, 1);
    cmd_erase = 1; tick(); idle_n(2); irq_in = 1; tick();
    chk("R4", "auto suspend set", stat_susp, 1);
    while (!suspended) tick();
    wr_ctl(0, 1);
    while (busy) tick();

    // R9: hold mode with program
    hold_mode = 1;
    cmd_prog = 1; tick(); irq_in = 1; tick();
    chk("R9", "held during program", irq_fire, 0);
    while (busy) tick();
    tick();
    idle_n(3);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 1500 == 0) hold_mode = $urandom_range(0, 1);
      cmd_erase = ($urandom_range(0, 19) == 0);
      cmd_prog  = ($urandom_range(0, 29) == 0);
      cmd_blk   = BW'($urandom_range(0, NBLK - 1));
      ctl_wr    = ($urandom_range(0, 14) == 0);
      ctl_susp  = ($urandom_range(0, 2) != 0);
      ctl_auto  = $urandom_range(0, 1);
      irq_in    = ($urandom_range(0, 24) == 0);
      acc_req   = ($urandom_range(0, 3) == 0);
      acc_blk   = BW'($urandom_range(0, NBLK - 1));
      tick();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule